// File: doc/BRIEF.md
# Sequential Multiply and Divide Unit

This block carries out 32-bit integer multiplication and division for a RISC core, signed or unsigned, over several clock cycles. A one-cycle start strobe hands it an operation code and two operands. It then holds a busy flag for a fixed number of cycles that depends on the operation, and signals completion with a one-cycle done pulse. Both result words are valid during that pulse.

The primary result goes to the destination register of the instruction. The secondary result always goes to general register r30. For multiplication, the two words are the low and high halves of the 64-bit product. For division, they are the quotient and the remainder. Latency does not depend on the operands, so the issuing pipeline can stall for a known number of cycles.

A zero divisor does not change the result registers. It raises an error flag alongside the done pulse and still takes the full divide latency.

Top module: `mdu_top`

## Requirements
- R1: While reset is low and after it is released, `busy`, `done` and `dz_err` are 0 and both result outputs are 0.
- R2: The multiply operations have a latency of 13 cycles. Multiply codes are `op` 2'b00 (signed) and 2'b01 (unsigned). After a start is accepted at a clock edge, `busy` is high for exactly 13 cycles, and `done` is high only in the last of those cycles.
- R3: The divide operations have their own latencies. Signed divide (`op` 2'b10) keeps `busy` high for exactly 38 cycles. Unsigned divide (`op` 2'b11) keeps it high for exactly 36 cycles. In both cases `done` is high only in the last busy cycle.
- R4: `done` is high for one cycle per operation. The result outputs change only in a cycle where `done` is high.
- R5: Signed multiply puts bits 31..0 of the signed 64-bit product on `res_lo` and bits 63..32 on `res_hi`.
- R6: Unsigned multiply puts bits 31..0 of the unsigned 64-bit product on `res_lo` and bits 63..32 on `res_hi`.
- R7: Signed divide puts the quotient on `res_lo`, rounded toward zero. It puts the remainder on `res_hi`, with the sign of the dividend `src_a`.
- R8: Unsigned divide puts `src_a / src_b` on `res_lo` and `src_a % src_b` on `res_hi`.
- R9: If `src_b` is 0 for either divide, `dz_err` is high in the `done` cycle only. Both result outputs keep their previous values, and the latency is still that of the divide.
- R10: Signed divide of 0x80000000 by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, with `dz_err` low.
- R11: A start strobe while `busy` is high is ignored. The running operation keeps its latency and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start strobe, accepted when not busy |
| op | input | 2 | 00 MUL, 01 MULU, 10 DIV, 11 DIVU |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| res_lo | output | 32 | Primary result to the destination register |
| res_hi | output | 32 | Secondary result to r30 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse qualifying results |
| dz_err | output | 1 | Zero-divisor flag, with done |

## Verification
The checker takes two things for granted.

First, an accepted start is a `start` sample taken while `busy` is low. The latency counter is armed from that sample, and the operation code is latched at that same point, not later.

Second, reset is held for more than one clock before operation, so the stability checks on the results never compare against pre-reset values.

The stimulus respects both. It raises `start` for a single cycle only when the unit is idle, except on purpose in the R11 cases, and it holds reset low for several cycles. The operand sweep covers sign boundaries, zero and all-ones values for all four operations.

// File: rtl/mdu_pkg.sv
// Package: shared operation codes for the multiply/divide unit.
// Assumes a 2-bit operation field decoded by the issuing core.
package mdu_pkg;
    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_MULU = 2'b01,
        OP_DIV  = 2'b10,
        OP_DIVU = 2'b11
    } mdu_op_e;
endpackage

// File: rtl/mdu_timer.sv
// Latency timer: holds busy for exactly 'lat' cycles after launch and
// flags the cycle before the last one so that results can be registered.
// Assumes lat >= 2 and that launch is only asserted while idle.
module mdu_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [CW-1:0] lat,
    output logic          busy,
    output logic          fire
);
    logic [CW-1:0] cnt;

    // Count down the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (launch) begin
            busy <= 1'b1;
            cnt  <= lat - CW'(1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CW'(1);
        end
    end

    // Fire one edge before the last busy cycle begins.
    assign fire = busy && (cnt == CW'(1));
endmodule

// File: rtl/mdu_mul_core.sv
// Multiply engine: sign-magnitude shift-and-add, RB multiplier bits per
// cycle, so it finishes within W/RB cycles of load. Assumes W % RB == 0.
module mdu_mul_core #(
    parameter int W  = 32,
    parameter int RB = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] acc, mcand;
    logic [W-1:0]  mplier;
    logic          neg;
    logic [W-1:0]  mag_a, mag_b;

    // Operand magnitudes for the signed form.
    always_comb begin
        mag_a = (sgn && a[W-1]) ? (~a + W'(1)) : a;
        mag_b = (sgn && b[W-1]) ? (~b + W'(1)) : b;
    end

    // Accumulate one multiplier digit per cycle until it is exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
            neg    <= 1'b0;
        end else if (load) begin
            acc    <= '0;
            mcand  <= {{W{1'b0}}, mag_a};
            mplier <= mag_b;
            neg    <= sgn && (a[W-1] ^ b[W-1]);
        end else if (mplier != '0) begin
            acc    <= acc + mcand * {{(PW-RB){1'b0}}, mplier[RB-1:0]};
            mcand  <= mcand << RB;
            mplier <= mplier >> RB;
        end
    end

    // Restore the sign of the product.
    assign prod = neg ? (~acc + PW'(1)) : acc;
endmodule

// File: rtl/mdu_div_core.sv
// Divide engine: restoring division on magnitudes, one quotient bit per
// cycle, finished W cycles after load. Result for a zero divisor is
// meaningless and must be discarded by the caller.
module mdu_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         sgn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int NW = $clog2(W + 1);

    logic [W-1:0]  quo_r, rem_r, dvs;
    logic [NW-1:0] left;
    logic          qneg, rneg;
    logic [W:0]    trial;
    logic [W-1:0]  mag_a, mag_b;

    // Operand magnitudes for the signed form.
    always_comb begin
        mag_a = (sgn && a[W-1]) ? (~a + W'(1)) : a;
        mag_b = (sgn && b[W-1]) ? (~b + W'(1)) : b;
        trial = {rem_r, quo_r[W-1]};
    end

    // Produce one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_r <= '0;
            rem_r <= '0;
            dvs   <= '0;
            left  <= '0;
            qneg  <= 1'b0;
            rneg  <= 1'b0;
        end else if (load) begin
            quo_r <= mag_a;
            rem_r <= '0;
            dvs   <= mag_b;
            left  <= NW'(W);
            qneg  <= sgn && (a[W-1] ^ b[W-1]);
            rneg  <= sgn && a[W-1];
        end else if (left != '0) begin
            left <= left - NW'(1);
            if (trial >= {1'b0, dvs}) begin
                rem_r <= W'(trial - {1'b0, dvs});
                quo_r <= {quo_r[W-2:0], 1'b1};
            end else begin
                rem_r <= trial[W-1:0];
                quo_r <= {quo_r[W-2:0], 1'b0};
            end
        end
    end

    // Apply truncation-toward-zero signs.
    assign quo = qneg ? (~quo_r + W'(1)) : quo_r;
    assign rem = rneg ? (~rem_r + W'(1)) : rem_r;
endmodule

// File: rtl/mdu_top.sv
// Multiply/divide unit top: accepts an operation while idle, runs the
// matching engine, and releases results after a fixed per-op latency.
// Assumes every latency >= 2 and long enough for its engine
// (multiply W/RB + 1 cycles, divide W + 1 cycles).
module mdu_top
    import mdu_pkg::*;
#(
    parameter int W        = 32,
    parameter int RB       = 4,
    parameter int LAT_MUL  = 13,
    parameter int LAT_MULU = 13,
    parameter int LAT_DIV  = 38,
    parameter int LAT_DIVU = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         busy,
    output logic         done,
    output logic         dz_err
);
    localparam int LM1  = (LAT_MUL > LAT_MULU) ? LAT_MUL : LAT_MULU;
    localparam int LM2  = (LAT_DIV > LAT_DIVU) ? LAT_DIV : LAT_DIVU;
    localparam int LMAX = (LM1 > LM2) ? LM1 : LM2;
    localparam int CW   = $clog2(LMAX + 1);

    mdu_op_e         op_in, op_q;
    logic            launch, fire, sgn, zero_q;
    logic [CW-1:0]   lat_sel;
    logic [2*W-1:0]  prod;
    logic [W-1:0]    quo, rem;

    assign op_in  = mdu_op_e'(op);
    assign launch = start && !busy;
    assign sgn    = (op_in == OP_MUL) || (op_in == OP_DIV);

    // Select the latency of the incoming operation.
    always_comb begin
        unique case (op_in)
            OP_MUL:  lat_sel = CW'(LAT_MUL);
            OP_MULU: lat_sel = CW'(LAT_MULU);
            OP_DIV:  lat_sel = CW'(LAT_DIV);
            default: lat_sel = CW'(LAT_DIVU);
        endcase
    end

    mdu_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .launch(launch), .lat(lat_sel),
        .busy(busy), .fire(fire)
    );

    mdu_mul_core #(.W(W), .RB(RB)) u_mul (
        .clk(clk), .rst_n(rst_n), .load(launch), .sgn(sgn),
        .a(src_a), .b(src_b), .prod(prod)
    );

    mdu_div_core #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(launch), .sgn(sgn),
        .a(src_a), .b(src_b), .quo(quo), .rem(rem)
    );

    // Latch the operation and the zero-divisor condition at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MUL;
            zero_q <= 1'b0;
        end else if (launch) begin
            op_q   <= op_in;
            zero_q <= (src_b == '0);
        end
    end

    // Register results, done and the error flag for the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
            done   <= 1'b0;
            dz_err <= 1'b0;
        end else if (fire) begin
            done <= 1'b1;
            if (op_q[1]) begin
                dz_err <= zero_q;
                if (!zero_q) begin
                    res_lo <= quo;
                    res_hi <= rem;
                end
            end else begin
                dz_err <= 1'b0;
                res_lo <= prod[W-1:0];
                res_hi <= prod[2*W-1:W];
            end
        end else begin
            done   <= 1'b0;
            dz_err <= 1'b0;
        end
    end
endmodule

// File: rtl/mdu_chk.sv
// Checker for mdu_top: protocol and latency properties, bound below.
// Assumes start samples taken while busy is low are accepted operations.
module mdu_chk #(
    parameter int W        = 32,
    parameter int LAT_MUL  = 13,
    parameter int LAT_MULU = 13,
    parameter int LAT_DIV  = 38,
    parameter int LAT_DIVU = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic         busy,
    input logic         done,
    input logic         dz_err
);
    int unsigned seen, want;

    // Reference count of busy cycles since the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 0;
            want <= 0;
        end else if (start && !busy) begin
            seen <= 1;
            case (op)
                2'b00:   want <= LAT_MUL;
                2'b01:   want <= LAT_MULU;
                2'b10:   want <= LAT_DIV;
                default: want <= LAT_DIVU;
            endcase
        end else if (busy) begin
            seen <= seen + 1;
        end
    end

    AST_DONE_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy && seen == want)); // R2 R3 R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R2
    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) (!$stable(res_lo) || !$stable(res_hi)) |-> done); // R4
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) dz_err |-> done); // R9
    AST_ERR_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) dz_err |-> ($stable(res_lo) && $stable(res_hi))); // R9
    AST_BUSY_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n) (busy && seen < want) |=> busy); // R11
endmodule

bind mdu_top mdu_chk #(
    .W(W), .LAT_MUL(LAT_MUL), .LAT_MULU(LAT_MULU),
    .LAT_DIV(LAT_DIV), .LAT_DIVU(LAT_DIVU)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .res_lo(res_lo), .res_hi(res_hi), .busy(busy), .done(done),
    .dz_err(dz_err)
);

// File: tb/sim_mdu_top.sv
module sim_mdu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] src_a = '0, src_b = '0;
    logic [31:0] res_lo, res_hi;
    logic        busy, done, dz_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] prev_lo = '0, prev_hi = '0;

    always #10 clk = ~clk;

    mdu_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .res_lo(res_lo), .res_hi(res_hi),
        .busy(busy), .done(done), .dz_err(dz_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected results computed arithmetically from the requirements.
    task automatic model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] lo, output logic [31:0] hi, output bit err, output int lat);
        longint sp;
        logic [63:0] up;
        err = 1'b0;
        lo = prev_lo;
        hi = prev_hi;
        case (o)
            2'b00: begin sp = longint'($signed(a)) * longint'($signed(b)); lo = sp[31:0]; hi = sp[63:32]; lat = 13; end
            2'b01: begin up = {32'b0, a} * {32'b0, b}; lo = up[31:0]; hi = up[63:32]; lat = 13; end
            2'b10: begin
                lat = 38;
                if (b == 0) err = 1'b1;
                else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin lo = a; hi = 0; end
                else begin lo = $signed(a) / $signed(b); hi = $signed(a) % $signed(b); end
            end
            default: begin
                lat = 36;
                if (b == 0) err = 1'b1;
                else begin lo = a / b; hi = a % b; end
            end
        endcase
    endtask

    task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input bit poke);
        logic [31:0] elo, ehi, glo, ghi;
        bit eerr, gerr;
        int lat, nb, nd, dpos, stray;
        string ltag, rtag;
        model(o, a, b, elo, ehi, eerr, lat);
        ltag = o[1] ? "R3" : "R2";
        case (o)
            2'b00: rtag = "R5";
            2'b01: rtag = "R6";
            2'b10: rtag = (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ? "R10" : "R7";
            default: rtag = "R8";
        endcase
        if (b == 0 && o[1]) rtag = "R9";
        @(negedge clk);
        op = o; src_a = a; src_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0; nd = 0; dpos = 0; stray = 0; glo = '0; ghi = '0; gerr = 1'b0;
        for (int i = 0; i < 100; i++) begin
            if (poke && nb == 4) begin
                start = 1'b1; op = ~o; src_a = ~a; src_b = b + 32'd3;
            end else start = 1'b0;
            if (!busy) break;
            nb++;
            if (done) begin nd++; dpos = nb; glo = res_lo; ghi = res_hi; gerr = dz_err; end
            else if (dz_err) stray++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(nb == lat && nd == 1 && dpos == lat, ltag, 64'(nb), 64'(lat));
        chk(nd == 1, "R4", 64'(nd), 64'd1);
        if (poke) chk(nb == lat && glo == elo && ghi == ehi, "R11", {glo, ghi}, {elo, ehi});
        chk(glo == elo && ghi == ehi, rtag, {glo, ghi}, {elo, ehi});
        chk(gerr == eerr && stray == 0, eerr ? "R9" : rtag, 64'(gerr), 64'(eerr));
        prev_lo = elo; prev_hi = ehi;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] vals [12];
        int n;
        vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h2, 32'h7, 32'hFFFF_FFF9,
                 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF,
                 32'h3, 32'hFFFF_FFFD};
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held
        chk(busy == 0 && done == 0 && dz_err == 0 && res_lo == 0 && res_hi == 0,
            "R1", {res_lo, res_hi}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && dz_err == 0 && res_lo == 0 && res_hi == 0,
            "R1", {31'd0, busy, 31'd0, done}, 64'd0);
        n = 0;
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++) begin
                    run_op(2'(o), vals[i], vals[j], (n % 37) == 5);
                    n++;
                end
        // R9: zero divisor right after a known result keeps it
        run_op(2'b11, 32'd100, 32'd7, 1'b0);
        run_op(2'b10, 32'd55, 32'd0, 1'b0);
        chk(res_lo == 32'd14 && res_hi == 32'd2, "R9", {res_lo, res_hi}, {32'd14, 32'd2});
        // R10 and R11 explicitly
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule